// File: doc/BRIEF.md
# Counter-Ramp Converter Controller

This block is the digital half of a counter-ramp analog-to-digital converter. It drives a parallel code into an external DAC and reads a single comparator bit. The comparator reads 0 while the analog input is still above the DAC output, and 1 once the DAC output has reached the input. A start pulse clears the code to zero and begins a ramp. The code steps up by one until the comparator reports a trip. The code at that moment is latched as the result, and a one-cycle done strobe is raised.

Each new code is held for a settle interval before the comparator is sampled. The interval covers the DAC and comparator loop delay, so that delay cannot push the count past the correct code. The code resolution and the length of the settle interval are parameters. Conversion time grows with the converted value. The top code stands for the range from one step below the reference up to the reference. An input that never trips the comparator therefore ends at all ones.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0, and dac_code_o and result_o are 0.
- R2: A start_i seen at a clock edge while busy_o is 0 sets dac_code_o to 0 and busy_o to 1 after that edge.
- R3: While busy, each code is held for SETTLE_CYCLES+1 clock edges. The comparator is sampled on the last of those edges. A sample of 0 below full scale raises the code by exactly 1.
- R4: A comparator sample of 1 stops the ramp. result_o then takes the code in use at that sample, and dac_code_o never goes beyond it.
- R5: If the first tripping code is T, done_o is high in the cycle after the edge that lies (T+1)*(SETTLE_CYCLES+1) edges after the start edge. The conversion time therefore grows with the input.
- R6: If code 2^WIDTH-1 (all ones, full scale) is sampled without a trip, the ramp stops there. result_o is all ones and done_o is still pulsed.
- R7: done_o is high for exactly one cycle per conversion. busy_o is 0 in that cycle and stays 1 in every cycle from the start until then.
- R8: start_i asserted while busy_o is 1 has no effect: the code is not cleared, and the result and timing match an undisturbed conversion.
- R9: result_o changes only in a cycle where done_o is high. It holds its value through idle time and through the whole next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion when idle |
| cmp_i | input | 1 | Comparator: 0 = input above DAC output, 1 = DAC reached input |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| result_o | output | WIDTH | Latched conversion result |
| done_o | output | 1 | One-cycle strobe when a result is latched |
| busy_o | output | 1 | High while a conversion is in progress |

## Verification
Each result is due at a fixed edge count after the start edge. For a first tripping code T (capped at full scale), the code in use k edges after the start is k/(SETTLE_CYCLES+1), rounded down, and the done strobe follows edge (T+1)*(SETTLE_CYCLES+1). The bench counts edges from the start edge and samples on falling edges. It compares the DAC code every cycle against that formula and the done edge against the product. It sweeps every target from 0 up to one beyond full scale, repeats one conversion with a start pulse injected mid-ramp, and watches result_o over idle gaps and over the following ramp.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH         = 8,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int CW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0]    WAIT_LOAD = CW'(SETTLE_CYCLES);
  localparam logic [WIDTH-1:0] FULL      = {WIDTH{1'b1}};

  logic             run_q;
  logic             done_q;
  logic [CW-1:0]    wait_q;
  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] res_q;

  wire sample = run_q && (wait_q == '0);
  wire stop   = sample && (cmp_i || code_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      wait_q <= '0;
      code_q <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q  <= 1'b1;
          code_q <= '0;
          wait_q <= WAIT_LOAD;
        end
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else if (stop) begin
        run_q  <= 1'b0;
        res_q  <= code_q;
        done_q <= 1'b1;
      end else begin
        code_q <= code_q + 1'b1;
        wait_q <= WAIT_LOAD;
      end
    end
  end

  assign dac_code_o = code_q;
  assign result_o   = res_q;
  assign done_o     = done_q;
  assign busy_o     = run_q;

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && dac_code_o == '0));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (dac_code_o == $past(dac_code_o) || dac_code_o == $past(dac_code_o) + 1'b1));

  assert_trip_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && cmp_i) |=> (done_o && result_o == $past(dac_code_o)));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && dac_code_o == FULL) |=> (done_o && result_o == FULL));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);
endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int S = 3;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [W-1:0] dac_code, result;
  logic done, busy;
  int target = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (int'(dac_code) >= target);

  ramp_adc_ctrl #(.WIDTH(W), .SETTLE_CYCLES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .dac_code_o(dac_code), .result_o(result), .done_o(done), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic convert(input int t, input int poke_at, input int old_res);
    int tt = (t > FULL) ? FULL : t;
    int due = (tt + 1) * (S + 1);
    int cyc = 0;
    bit code_ok = 1'b1, busy_ok = 1'b1, hold_ok = 1'b1;
    int bad_code = 0;
    @(negedge clk);
    target = t;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy && dac_code == 0, "R2", int'(dac_code), 0);
    while (!done && cyc < 200) begin
      if (int'(dac_code) != cyc / (S + 1)) begin code_ok = 1'b0; bad_code = int'(dac_code); end
      if (!busy) busy_ok = 1'b0;
      if (int'(result) != old_res) hold_ok = 1'b0;
      start = (cyc == poke_at);
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    check(code_ok, "R3 R4 R8 code ramp", bad_code, -1);
    check(busy_ok, "R7 busy during ramp", 0, 1);
    check(hold_ok, "R9 result held during ramp", int'(result), old_res);
    check(cyc == due, "R5 conversion edges", cyc, due);
    check(done && int'(result) == tt, (t > FULL) ? "R6 saturated result" : "R4 result", int'(result), tt);
    check(!busy, "R7 busy low with done", int'(busy), 0);
    check(int'(dac_code) <= tt, "R4 no overshoot", int'(dac_code), tt);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    int last;
    repeat (3) @(negedge clk);
    check(!busy && !done && dac_code == 0 && result == 0, "R1 reset state",
          int'({busy, done, dac_code, result}), 0);
    rst_n = 1'b1;
    last = 0;
    for (int t = 0; t <= FULL + 1; t++) begin
      convert(t, -1, last);
      last = (t > FULL) ? FULL : t;
      target = (t * 7) % (FULL + 1);
      repeat (4) @(negedge clk);
      check(int'(result) == last && !busy && !done, "R9 result held idle", int'(result), last);
    end
    convert(9, 10, last);
    last = 9;
    convert(5, 0, last);
    last = 5;
    convert(FULL, 3 * (S + 1), last);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule